// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Generator

This block produces the two programmable watermark flags of a FIFO whose write side and read side run on unrelated clocks. It does not hold any data. It receives the binary write pointer in the write clock domain and the binary read pointer in the read clock domain. Each pointer is one bit wider than the address, so the word count is their difference modulo twice the depth. Each pointer crosses to the other domain as Gray code through a two-flop synchronizer. Two offset registers, one for the empty side and one for the full side, are loaded from an 18-bit bus on the write clock. The almost-empty flag is active when the count is at or below the empty offset. The almost-full flag is active when the free space is at or below the full offset. Both flags are active low.

Three configuration pins are captured while master reset is held and the write-domain reset synchronizer is still low. After that they are ignored.

- The timing pin selects one of two styles:
  - Single-clock style: the almost-empty flag is a read-clock register and the almost-full flag is a write-clock register.
  - Split-clock style: a flag is driven active by the clock of the side whose activity fills or drains toward its threshold. It is released by the clock of the opposite side.
- The bus-width pin tells the offset loader how wide the bus is.
- The parity pin tells the offset loader whether, on a wide bus, bit 8 carries parity.

Top module: `pflag_gen`

## Requirements
- R1: After master reset, almost_empty_n_o is 0 and almost_full_n_o is 1, and both offsets are 7.
- R2: sync_mode_i, wide_bus_i and par_inter_i are taken only while reset is active. Changing them afterwards has no effect until the next master reset.
- R3: The word count is (wptr_i - rptr_i) mod 2^(ADDR_W+1). Once settled, almost_empty_n_o is 0 exactly when the count is at or below the empty offset.
- R4: The free space is 2^ADDR_W minus the count. Once settled, almost_full_n_o is 0 exactly when the free space is at or below the full offset.
- R5: With sync_mode_i = 1 at reset, almost_empty_n_o changes only on rising rclk edges, never on wclk edges alone.
- R6: With sync_mode_i = 1 at reset, almost_full_n_o changes only on rising wclk edges, never on rclk edges alone.
- R7: With sync_mode_i = 0 at reset, almost_full_n_o falls only on a rising wclk edge and rises only on a rising rclk edge.
- R8: With sync_mode_i = 0 at reset, almost_empty_n_o falls only on a rising rclk edge and rises only on a rising wclk edge.
- R9: A rising wclk edge with ld_empty_off_i = 1 loads the empty offset, and one with ld_full_off_i = 1 loads the full offset. Without its strobe, an offset holds its value.
- R10: If wide_bus_i = 1 and par_inter_i = 1, the loaded offset is the 17-bit value {off_data_i[17:9], off_data_i[7:0]}, and bit 8 is ignored.
- R11: If wide_bus_i = 1 and par_inter_i = 0, the loaded offset is off_data_i[15:0]. Bit 8 is an ordinary value bit, and bits 16 and 17 are ignored.
- R12: If wide_bus_i = 0, the loaded offset is off_data_i[8:0] zero-extended. Bits 9 to 17 and par_inter_i have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| sync_mode_i | input | 1 | Taken at reset: 1 = single-clock flag timing, 0 = split-clock |
| wide_bus_i | input | 1 | Taken at reset: 1 = 18-bit offset bus, 0 = 9-bit |
| par_inter_i | input | 1 | Taken at reset: 1 = bit 8 of a wide bus is parity |
| ld_empty_off_i | input | 1 | Load strobe for the empty offset (wclk) |
| ld_full_off_i | input | 1 | Load strobe for the full offset (wclk) |
| off_data_i | input | 18 | Offset value bus |
| wptr_i | input | ADDR_W+1 | Binary write pointer, wclk domain |
| rptr_i | input | ADDR_W+1 | Binary read pointer, rclk domain |
| almost_empty_n_o | output | 1 | Almost-empty flag, active low |
| almost_full_n_o | output | 1 | Almost-full flag, active low |

## Verification
The assertions rely on these input conditions:
- The configuration pins stay constant while reset is held.
- Each pointer changes only in its own clock domain.
- Clocks stop only in their low phase, so that a clock-edge tally in the checker reflects every real edge.

The stimulus meets these conditions in the following ways:
- It drives each pointer half a period away from its own rising edge.
- It loads offsets while the pointers are idle, because the read side uses the empty offset as a quasi-static value.
- It gates a clock only while that clock is low.

Pointers jump by many positions at once in the stimulus. A zero-delay model samples such a jump coherently, although real hardware would step the pointers one at a time.

// File: rtl/pflag_pkg.sv
package pflag_pkg;
  localparam int BUS_W    = 18;
  localparam int OFF_W    = BUS_W - 1;
  localparam int PAR_BIT  = 8;
  localparam int NARROW_W = 9;
  localparam int LOW_W    = 16;

  typedef enum logic {FLAG_SPLIT = 1'b0, FLAG_SYNC = 1'b1} flag_mode_e;

  // Offset value extracted from the load bus for each bus/parity layout.
  function automatic logic [OFF_W-1:0] pick_offset(input logic [BUS_W-1:0] d,
                                                   input logic wide,
                                                   input logic inter);
    logic [OFF_W-1:0] v;
    if (!wide)
      v = {{(OFF_W-NARROW_W){1'b0}}, d[NARROW_W-1:0]};
    else if (inter)
      v = {d[BUS_W-1:PAR_BIT+1], d[PAR_BIT-1:0]};
    else
      v = {{(OFF_W-LOW_W){1'b0}}, d[LOW_W-1:0]};
    return v;
  endfunction
endpackage

// File: rtl/pflag_rst_sync.sv
module pflag_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/pflag_ptr_sync.sv
module pflag_ptr_sync #(
  parameter int W = 11
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic [W-1:0] bin_i,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] gray_d, gray_q, meta_q, safe_q;

  assign gray_d = bin_i ^ (bin_i >> 1);

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) gray_q <= '0;
    else            gray_q <= gray_d;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      meta_q <= '0;
      safe_q <= '0;
    end else begin
      meta_q <= gray_q;
      safe_q <= meta_q;
    end
  end

  // Gray to binary: each bit is the parity of all bits at or above it.
  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_o[i] = ^safe_q[W-1:i];
  end
endmodule

// File: rtl/pflag_xflag.sv
// Flag set from domain A and released from domain B through a pair of toggles.
module pflag_xflag #(
  parameter bit INIT_ACTIVE = 1'b0
) (
  input  logic a_clk,
  input  logic a_rst_n,
  input  logic a_want,
  input  logic b_clk,
  input  logic b_rst_n,
  input  logic b_want,
  output logic active_o
);
  logic       ta_q, ta_d, tb_q, tb_d;
  logic [1:0] ta_in_b_q, tb_in_a_q;
  logic       a_view, b_view;

  always_comb begin
    a_view = ta_q ^ tb_in_a_q[1] ^ INIT_ACTIVE;
    b_view = ta_in_b_q[1] ^ tb_q ^ INIT_ACTIVE;
    ta_d   = ta_q ^ (a_want & ~a_view);
    tb_d   = tb_q ^ (b_view & ~b_want);
  end

  always_ff @(posedge a_clk or negedge a_rst_n) begin
    if (!a_rst_n) begin
      ta_q      <= 1'b0;
      tb_in_a_q <= 2'b00;
    end else begin
      ta_q      <= ta_d;
      tb_in_a_q <= {tb_in_a_q[0], tb_q};
    end
  end

  always_ff @(posedge b_clk or negedge b_rst_n) begin
    if (!b_rst_n) begin
      tb_q      <= 1'b0;
      ta_in_b_q <= 2'b00;
    end else begin
      tb_q      <= tb_d;
      ta_in_b_q <= {ta_in_b_q[0], ta_q};
    end
  end

  assign active_o = ta_q ^ tb_q ^ INIT_ACTIVE;
endmodule

// File: rtl/pflag_gen.sv
module pflag_gen
  import pflag_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int RST_OFF = 7
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst_n,
  input  logic              sync_mode_i,
  input  logic              wide_bus_i,
  input  logic              par_inter_i,
  input  logic              ld_empty_off_i,
  input  logic              ld_full_off_i,
  input  logic [BUS_W-1:0]  off_data_i,
  input  logic [ADDR_W:0]   wptr_i,
  input  logic [ADDR_W:0]   rptr_i,
  output logic              almost_empty_n_o,
  output logic              almost_full_n_o
);
  localparam int               PTR_W   = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_V = PTR_W'(1) << ADDR_W;
  localparam logic [OFF_W-1:0] RST_V   = OFF_W'(RST_OFF);

  logic wrst_n, rrst_n;

  pflag_rst_sync u_wrst (.clk(wclk), .arst_n(mrst_n), .rst_n_o(wrst_n));
  pflag_rst_sync u_rrst (.clk(rclk), .arst_n(mrst_n), .rst_n_o(rrst_n));

  // Configuration captured while the write-domain reset is held.
  flag_mode_e mode_q, mode_d;
  logic       wide_q, wide_d, inter_q, inter_d;

  always_comb begin
    mode_d  = mode_q;
    wide_d  = wide_q;
    inter_d = inter_q;
    if (!wrst_n) begin
      mode_d  = flag_mode_e'(sync_mode_i);
      wide_d  = wide_bus_i;
      inter_d = par_inter_i;
    end
  end

  always_ff @(posedge wclk) begin
    mode_q  <= mode_d;
    wide_q  <= wide_d;
    inter_q <= inter_d;
  end

  // Offset registers.
  logic [OFF_W-1:0] eoff_q, eoff_d, foff_q, foff_d, cand;

  always_comb begin
    cand   = pick_offset(off_data_i, wide_q, inter_q);
    eoff_d = ld_empty_off_i ? cand : eoff_q;
    foff_d = ld_full_off_i  ? cand : foff_q;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      eoff_q <= RST_V;
      foff_q <= RST_V;
    end else begin
      eoff_q <= eoff_d;
      foff_q <= foff_d;
    end
  end

  // Pointer crossings.
  logic [PTR_W-1:0] rptr_w, wptr_r;

  pflag_ptr_sync #(.W(PTR_W)) u_r2w (
    .src_clk(rclk), .src_rst_n(rrst_n), .bin_i(rptr_i),
    .dst_clk(wclk), .dst_rst_n(wrst_n), .bin_o(rptr_w)
  );

  pflag_ptr_sync #(.W(PTR_W)) u_w2r (
    .src_clk(wclk), .src_rst_n(wrst_n), .bin_i(wptr_i),
    .dst_clk(rclk), .dst_rst_n(rrst_n), .bin_o(wptr_r)
  );

  // Threshold compares, one set per domain.
  logic [PTR_W-1:0] cnt_w, free_w, cnt_r, free_r;
  logic             full_w, empty_w, full_r, empty_r;

  always_comb begin
    cnt_w   = wptr_i - rptr_w;
    free_w  = DEPTH_V - cnt_w;
    cnt_r   = wptr_r - rptr_i;
    free_r  = DEPTH_V - cnt_r;
    full_w  = OFF_W'(free_w) <= foff_q;
    empty_w = OFF_W'(cnt_w)  <= eoff_q;
    full_r  = OFF_W'(free_r) <= foff_q;
    empty_r = OFF_W'(cnt_r)  <= eoff_q;
  end

  // Single-clock style registers.
  logic paf_sync_q, pae_sync_q;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) paf_sync_q <= 1'b0;
    else         paf_sync_q <= full_w;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) pae_sync_q <= 1'b1;
    else         pae_sync_q <= empty_r;
  end

  // Split-clock style flags.
  logic paf_split, pae_split;

  pflag_xflag #(.INIT_ACTIVE(1'b0)) u_xfull (
    .a_clk(wclk), .a_rst_n(wrst_n), .a_want(full_w),
    .b_clk(rclk), .b_rst_n(rrst_n), .b_want(full_r),
    .active_o(paf_split)
  );

  pflag_xflag #(.INIT_ACTIVE(1'b1)) u_xempty (
    .a_clk(rclk), .a_rst_n(rrst_n), .a_want(empty_r),
    .b_clk(wclk), .b_rst_n(wrst_n), .b_want(empty_w),
    .active_o(pae_split)
  );

  assign almost_full_n_o  = ~((mode_q == FLAG_SYNC) ? paf_sync_q : paf_split);
  assign almost_empty_n_o = ~((mode_q == FLAG_SYNC) ? pae_sync_q : pae_split);
endmodule

// File: rtl/pflag_gen_chk.sv
module pflag_gen_chk
  import pflag_pkg::*;
(
  input logic             wclk,
  input logic             rclk,
  input logic             wrst_n,
  input logic             rrst_n,
  input logic             mode_sync,
  input logic             ld_empty,
  input logic             ld_full,
  input logic [OFF_W-1:0] eoff,
  input logic [OFF_W-1:0] foff,
  input logic             pae_n,
  input logic             paf_n
);
  logic [7:0] wclk_cnt, rclk_cnt;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) wclk_cnt <= '0;
    else         wclk_cnt <= wclk_cnt + 8'd1;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) rclk_cnt <= '0;
    else         rclk_cnt <= rclk_cnt + 8'd1;
  end

  a_r2_mode_held: assert property (@(posedge wclk) disable iff (!wrst_n)
    $stable(mode_sync));

  a_r5_sync_empty_rclk_only: assert property (@(posedge wclk) disable iff (!(wrst_n && rrst_n))
    (mode_sync && $stable(rclk_cnt)) |-> $stable(pae_n));

  a_r6_sync_full_wclk_only: assert property (@(posedge rclk) disable iff (!(wrst_n && rrst_n))
    (mode_sync && $stable(wclk_cnt)) |-> $stable(paf_n));

  a_r7_full_sets_on_wclk: assert property (@(posedge rclk) disable iff (!(wrst_n && rrst_n))
    (!mode_sync && $stable(wclk_cnt)) |-> !$fell(paf_n));

  a_r7_full_clears_on_rclk: assert property (@(posedge wclk) disable iff (!(wrst_n && rrst_n))
    (!mode_sync && $stable(rclk_cnt)) |-> !$rose(paf_n));

  a_r8_empty_sets_on_rclk: assert property (@(posedge wclk) disable iff (!(wrst_n && rrst_n))
    (!mode_sync && $stable(rclk_cnt)) |-> !$fell(pae_n));

  a_r8_empty_clears_on_wclk: assert property (@(posedge rclk) disable iff (!(wrst_n && rrst_n))
    (!mode_sync && $stable(wclk_cnt)) |-> !$rose(pae_n));

  a_r9_empty_off_holds: assert property (@(posedge wclk) disable iff (!wrst_n)
    !ld_empty |=> $stable(eoff));

  a_r9_full_off_holds: assert property (@(posedge wclk) disable iff (!wrst_n)
    !ld_full |=> $stable(foff));
endmodule

bind pflag_gen pflag_gen_chk u_chk (
  .wclk     (wclk),
  .rclk     (rclk),
  .wrst_n   (wrst_n),
  .rrst_n   (rrst_n),
  .mode_sync(mode_q),
  .ld_empty (ld_empty_off_i),
  .ld_full  (ld_full_off_i),
  .eoff     (eoff_q),
  .foff     (foff_q),
  .pae_n    (almost_empty_n_o),
  .paf_n    (almost_full_n_o)
);

// File: tb/pflag_gen_tb.sv
`timescale 1ns/100ps
module pflag_gen_tb;
  localparam int AW = 10;
  localparam int PW = AW + 1;

  logic wclk_raw, rclk_raw, wclk_en, rclk_en, wclk, rclk;
  logic mrst_n, sync_mode, wide_bus, par_inter, ld_e, ld_f;
  logic [17:0] din;
  logic [PW-1:0] wptr, rptr;
  logic pae_n, paf_n;

  int checks, errors;
  bit done;

  typedef struct {
    logic  pae;
    logic  paf;
    string tag;
  } exp_t;
  exp_t sb_q[$];
  event chk_ev;

  initial wclk_raw = 1'b0;
  always #2.5 wclk_raw = ~wclk_raw;
  initial rclk_raw = 1'b0;
  always #3.6 rclk_raw = ~rclk_raw;
  assign wclk = wclk_raw & wclk_en;
  assign rclk = rclk_raw & rclk_en;

  pflag_gen #(.ADDR_W(AW)) u_dut (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n),
    .sync_mode_i(sync_mode), .wide_bus_i(wide_bus), .par_inter_i(par_inter),
    .ld_empty_off_i(ld_e), .ld_full_off_i(ld_f), .off_data_i(din),
    .wptr_i(wptr), .rptr_i(rptr),
    .almost_empty_n_o(pae_n), .almost_full_n_o(paf_n)
  );

  // Monitor: pops expected flag pairs and compares them with the outputs.
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (pae_n !== e.pae || paf_n !== e.paf) begin
          errors++;
          $display("FAIL %s: pae_n=%b paf_n=%b expected pae_n=%b paf_n=%b",
                   e.tag, pae_n, paf_n, e.pae, e.paf);
        end
      end
    end
  end

  task automatic expect_flags(input logic pae, input logic paf, input string tag);
    exp_t e;
    e.pae = pae; e.paf = paf; e.tag = tag;
    sb_q.push_back(e);
    ->chk_ev;
    #1;
  endtask

  task automatic settle();
    repeat (8) @(posedge wclk_raw);
    repeat (8) @(posedge rclk_raw);
    @(negedge wclk_raw);
  endtask

  task automatic set_w(input int v);
    @(negedge wclk_raw);
    wptr = PW'(v);
  endtask

  task automatic set_r(input int v);
    @(negedge rclk_raw);
    rptr = PW'(v);
  endtask

  task automatic gate_w(input logic en);
    @(negedge wclk_raw);
    wclk_en = en;
  endtask

  task automatic gate_r(input logic en);
    @(negedge rclk_raw);
    rclk_en = en;
  endtask

  task automatic load(input logic e, input logic f, input logic [17:0] v);
    @(negedge wclk_raw);
    din = v; ld_e = e; ld_f = f;
    @(negedge wclk_raw);
    ld_e = 1'b0; ld_f = 1'b0;
  endtask

  task automatic do_reset(input logic sm, input logic wb, input logic pi);
    mrst_n = 1'b0;
    sync_mode = sm; wide_bus = wb; par_inter = pi;
    wptr = '0; rptr = '0;
    wclk_en = 1'b1; rclk_en = 1'b1;
    repeat (4) @(posedge rclk_raw);
    @(negedge wclk_raw);
    mrst_n = 1'b1;
    settle();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #500us;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    ld_e = 1'b0; ld_f = 1'b0; din = '0;

    // Single-clock style, wide bus, parity not interspersed.
    do_reset(1'b1, 1'b1, 1'b0);
    expect_flags(1'b0, 1'b1, "R1 reset state");

    set_w(7);    settle(); expect_flags(1'b0, 1'b1, "R3 count 7 at default offset");
    set_w(8);    settle(); expect_flags(1'b1, 1'b1, "R3 count 8 above offset");
    set_w(1016); settle(); expect_flags(1'b1, 1'b1, "R4 free 8 above offset");
    set_w(1017); settle(); expect_flags(1'b1, 1'b0, "R4 R1 free 7 at default offset");
    set_r(2040); set_w(2045); settle(); expect_flags(1'b0, 1'b1, "R3 count 5 near wrap");
    set_r(2045); set_w(7);    settle(); expect_flags(1'b1, 1'b1, "R3 count 10 across wrap");

    // R11: bits 16/17 ignored, bit 8 used -> 0x120 = 288.
    load(1'b1, 1'b0, 18'h3_0120);
    settle(); expect_flags(1'b0, 1'b1, "R9 R11 count 10 below loaded offset");
    set_w((2045 + 288) % 2048); settle(); expect_flags(1'b0, 1'b1, "R11 count 288");
    set_w((2045 + 289) % 2048); settle(); expect_flags(1'b1, 1'b1, "R11 count 289");
    load(1'b0, 1'b1, 18'h0_0010);
    set_r(0); set_w(1008); settle(); expect_flags(1'b1, 1'b0, "R11 free 16");
    @(negedge wclk_raw); din = 18'h0;
    repeat (6) @(negedge wclk_raw);
    set_w(1007); settle(); expect_flags(1'b1, 1'b1, "R9 free 17, offset held at 16");

    // R2/R5: pin flips after reset must not change the captured style.
    sync_mode = 1'b0;
    set_w(300); settle(); expect_flags(1'b1, 1'b1, "R5 count 300");
    gate_r(1'b0);
    set_r(20);
    repeat (10) @(posedge wclk_raw); @(negedge wclk_raw);
    expect_flags(1'b1, 1'b1, "R5 R2 empty flag held without rclk");
    gate_r(1'b1); settle(); expect_flags(1'b0, 1'b1, "R5 empty flag after rclk");

    gate_w(1'b0);
    set_w(1028);
    repeat (10) @(posedge rclk_raw); @(negedge wclk_raw);
    expect_flags(1'b0, 1'b1, "R6 full flag held without wclk");
    gate_w(1'b1); settle(); expect_flags(1'b1, 1'b0, "R6 full flag after wclk");

    // Split-clock style, wide bus, interspersed parity.
    do_reset(1'b0, 1'b1, 1'b1);
    expect_flags(1'b0, 1'b1, "R1 reset state again");
    load(1'b1, 1'b0, 18'h0_0105);   // bit 8 dropped -> 5
    load(1'b0, 1'b1, 18'h0_0205);   // {bit9, low byte} -> 261
    set_w(5);   settle(); expect_flags(1'b0, 1'b1, "R10 count 5");
    set_w(6);   settle(); expect_flags(1'b1, 1'b1, "R10 count 6");
    set_w(763); settle(); expect_flags(1'b1, 1'b0, "R10 free 261");
    set_w(762); settle(); expect_flags(1'b1, 1'b1, "R10 free 262");

    set_w(700); settle();
    gate_r(1'b0);
    set_w(763);
    repeat (10) @(posedge wclk_raw); @(negedge wclk_raw);
    expect_flags(1'b1, 1'b0, "R7 full set by wclk alone");
    gate_r(1'b1); settle();
    gate_w(1'b0);
    set_r(10);
    repeat (10) @(posedge rclk_raw); @(negedge wclk_raw);
    expect_flags(1'b1, 1'b1, "R7 full released by rclk alone");
    gate_w(1'b1); settle(); expect_flags(1'b1, 1'b1, "R7 stays released");

    gate_w(1'b0);
    set_r(760);
    repeat (10) @(posedge rclk_raw); @(negedge wclk_raw);
    expect_flags(1'b0, 1'b1, "R8 empty set by rclk alone");
    gate_w(1'b1); settle();
    gate_r(1'b0);
    set_w(780);
    repeat (10) @(posedge wclk_raw); @(negedge wclk_raw);
    expect_flags(1'b1, 1'b1, "R8 empty released by wclk alone");
    gate_r(1'b1); settle(); expect_flags(1'b1, 1'b1, "R8 stays released");

    // Narrow bus with parity pin set: low 9 bits only -> 0x140 = 320.
    do_reset(1'b1, 1'b0, 1'b1);
    load(1'b1, 1'b0, 18'h3_FF40);
    set_w(320); settle(); expect_flags(1'b0, 1'b1, "R12 count 320");
    set_w(321); settle(); expect_flags(1'b1, 1'b1, "R12 count 321");

    #20;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule